// File: doc/BRIEF.md
# Falling-Block Playfield Occupancy Grid

This block keeps the occupancy state of a small falling-block game board of 5 columns by 7 rows. Every cell is one flag that reads 1 once a block has settled there. Game logic addresses cells by a 3-bit column `x` and a 3-bit row `y`. Row `y = 0` is the bottom row and `y = 6` is the top row. There are three lookup ports and three set ports, so a whole three-cell piece can be probed or landed in one cycle. The full board is also visible as a 35-bit vector for a display driver.

When the bottom row is completely filled, the block raises a row-full flag. On the next progress tick it moves every row down by one and brings in an empty top row. Each such clear adds one to a score counter. A move judge decides whether the active piece may go left, right or down. It takes the three candidate coordinates that the piece would occupy after the move. A move is refused if a candidate falls past an edge, using fixed wrap-around codes, or if a candidate lands on a settled cell.

Top module: `playfield_grid`

## Requirements
- R1: Driving `rst_n` low empties all 35 cells and zeroes the score at once, without waiting for a clock edge.
- R2: Lookup port p returns 1 only when (`rd_x[p]`, `rd_y[p]`) lies inside the board (x < 5, y < 7) and that cell is set. Any coordinate outside the board reads 0. Port p uses bits [3p+2:3p] of the x and y buses.
- R3: On a clock edge, every set port whose enable is high and whose coordinate is inside the board sets its cell to 1. A set port with an off-board coordinate changes nothing. Cell (x,y) appears at bit y*5+x of `occ`.
- R4: Apart from reset and the row shift, a set cell never returns to 0.
- R5: `row_full` is high exactly when all five cells of row y = 0 are set.
- R6: At a clock edge where `tick` is high and `row_full` is high, each cell (x,y) takes the old value of (x,y+1), and row 6 becomes empty. With `tick` low, no shift takes place.
- R7: `score` rises by one on every row shift, and by nothing otherwise. It wraps from 255 to 0.
- R8: When a write and a row shift share an edge, the shift is applied first and the written cells are then set at their given coordinates in the shifted board.
- R9: The `move` code is 00 for none, 01 for left, 10 for right and 11 for down. `blocked` is high when a left move has any candidate x = 111, when a right move has any candidate x = 101, or when a down move has any candidate y = 111.
- R10: For a move other than none, `blocked` is also high when any on-board candidate cell is set. Off-board candidates are not looked up. With `move` = none, `blocked` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low board clear |
| tick | input | 1 | Progress tick that allows a pending row shift |
| wr_en | input | 3 | Set-port enables |
| wr_x | input | 9 | Set-port columns, 3 bits per port |
| wr_y | input | 9 | Set-port rows, 3 bits per port |
| rd_x | input | 9 | Lookup-port columns, 3 bits per port |
| rd_y | input | 9 | Lookup-port rows, 3 bits per port |
| rd_hit | output | 3 | Lookup results |
| move | input | 2 | Requested piece move |
| cand_x | input | 9 | Candidate columns of the three piece cells |
| cand_y | input | 9 | Candidate rows of the three piece cells |
| blocked | output | 1 | Move refused |
| occ | output | 35 | Whole-board occupancy, bit y*5+x |
| row_full | output | 1 | Bottom row completely filled |
| score | output | 8 | Number of rows cleared |

## Verification
A wrong cell flag appears on `occ` one edge after the write or shift that caused it. It then spreads to `rd_hit`, `blocked` and `row_full` in the same cycle. A missed or doubled shift moves every upper row to the wrong place, and the score drifts at the same edge. A lost or early score step stays visible until reset, because nothing else ever changes the counter. The move judge is combinational, so a wrong edge code or a wrong skipped lookup shows on `blocked` in the very cycle the candidates are presented.

// File: rtl/grid_pkg.sv
package grid_pkg;

  typedef enum logic [1:0] {
    MV_NONE  = 2'b00,
    MV_LEFT  = 2'b01,
    MV_RIGHT = 2'b10,
    MV_DOWN  = 2'b11
  } move_e;

  function automatic bit in_grid(input int x, input int y, input int cols, input int rows);
    return (x >= 0) && (x < cols) && (y >= 0) && (y < rows);
  endfunction

  function automatic int cell_index(input int x, input int y, input int cols);
    return y * cols + x;
  endfunction

  // Edge code test: left and down wrap to all ones, right steps to COLS.
  function automatic bit edge_hit(input move_e d, input int x, input int y,
                                  input int wrap_code, input int right_code);
    case (d)
      MV_LEFT:  return x == wrap_code;
      MV_RIGHT: return x == right_code;
      MV_DOWN:  return y == wrap_code;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/grid_store.sv
module grid_store
  import grid_pkg::*;
#(
  parameter int COLS = 5,
  parameter int ROWS = 7,
  parameter int CW   = 3,
  parameter int NWR  = 3,
  localparam int CELLS = COLS * ROWS,
  localparam int IW    = $clog2(CELLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [NWR-1:0]      wr_en,
  input  logic [NWR*CW-1:0]   wr_x,
  input  logic [NWR*CW-1:0]   wr_y,
  output logic [CELLS-1:0]    occ,
  output logic                row_full,
  output logic                shift_fire
);

  logic [CELLS-1:0] shifted;
  logic [CELLS-1:0] wr_mask;
  logic [CELLS-1:0] occ_nx;

  assign row_full   = &occ[COLS-1:0];
  assign shift_fire = tick & row_full;
  assign shifted    = {{COLS{1'b0}}, occ[CELLS-1:COLS]};

  always_comb begin
    wr_mask = '0;
    for (int p = 0; p < NWR; p++) begin
      if (wr_en[p] && in_grid(int'(wr_x[p*CW +: CW]), int'(wr_y[p*CW +: CW]), COLS, ROWS))
        wr_mask[IW'(cell_index(int'(wr_x[p*CW +: CW]), int'(wr_y[p*CW +: CW]), COLS))] = 1'b1;
    end
  end

  // Per-cell multiplexer: keep or take the cell above, then merge writes.
  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assign occ_nx[c] = (shift_fire ? shifted[c] : occ[c]) | wr_mask[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_nx;
  end

  assert_reset_empty_R1: assert property (@(posedge clk) !rst_n |-> occ == '0);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> ((occ & $past(occ)) == $past(occ)));

  assert_shift_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && wr_en == '0) |=> occ == {{COLS{1'b0}}, $past(occ[CELLS-1:COLS])});

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask != '0) |=> ((occ & $past(wr_mask)) == $past(wr_mask)));

endmodule

// File: rtl/grid_reader.sv
module grid_reader
  import grid_pkg::*;
#(
  parameter int COLS = 5,
  parameter int ROWS = 7,
  parameter int CW   = 3,
  parameter int NRD  = 3,
  localparam int CELLS = COLS * ROWS,
  localparam int IW    = $clog2(CELLS)
) (
  input  logic [CELLS-1:0]  occ,
  input  logic [NRD*CW-1:0] rd_x,
  input  logic [NRD*CW-1:0] rd_y,
  output logic [NRD-1:0]    rd_hit
);

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic on_board;
    assign on_board  = in_grid(int'(rd_x[p*CW +: CW]), int'(rd_y[p*CW +: CW]), COLS, ROWS);
    assign rd_hit[p] = on_board &&
                       occ[IW'(cell_index(int'(rd_x[p*CW +: CW]), int'(rd_y[p*CW +: CW]), COLS))];
  end

endmodule

// File: rtl/move_judge.sv
module move_judge
  import grid_pkg::*;
#(
  parameter int COLS = 5,
  parameter int ROWS = 7,
  parameter int CW   = 3,
  parameter int NPC  = 3,
  localparam int CELLS     = COLS * ROWS,
  localparam int IW        = $clog2(CELLS),
  localparam int WRAP_CODE = (1 << CW) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  move_e             move,
  input  logic [NPC*CW-1:0] cand_x,
  input  logic [NPC*CW-1:0] cand_y,
  input  logic [CELLS-1:0]  occ,
  output logic              blocked
);

  logic bnd_hit;
  logic occ_hit;

  always_comb begin
    bnd_hit = 1'b0;
    occ_hit = 1'b0;
    for (int p = 0; p < NPC; p++) begin
      if (edge_hit(move, int'(cand_x[p*CW +: CW]), int'(cand_y[p*CW +: CW]), WRAP_CODE, COLS))
        bnd_hit = 1'b1;
      if (in_grid(int'(cand_x[p*CW +: CW]), int'(cand_y[p*CW +: CW]), COLS, ROWS) &&
          occ[IW'(cell_index(int'(cand_x[p*CW +: CW]), int'(cand_y[p*CW +: CW]), COLS))])
        occ_hit = 1'b1;
    end
  end

  assign blocked = (move != MV_NONE) && (bnd_hit || occ_hit);

  assert_edge_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_hit |-> blocked);

  assert_idle_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_NONE) |-> !blocked);

endmodule

// File: rtl/row_score.sv
module row_score #(
  parameter int SCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bump,
  output logic [SCW-1:0] score
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    score <= '0;
    else if (bump) score <= score + 1'b1;
  end

  assert_score_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> score == $past(score) + 1'b1);

  assert_score_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(score));

endmodule

// File: rtl/playfield_grid.sv
module playfield_grid
  import grid_pkg::*;
#(
  parameter int COLS = 5,
  parameter int ROWS = 7,
  parameter int CW   = 3,
  parameter int NRD  = 3,
  parameter int NWR  = 3,
  parameter int NPC  = 3,
  parameter int SCW  = 8,
  localparam int CELLS = COLS * ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*CW-1:0] wr_x,
  input  logic [NWR*CW-1:0] wr_y,
  input  logic [NRD*CW-1:0] rd_x,
  input  logic [NRD*CW-1:0] rd_y,
  output logic [NRD-1:0]    rd_hit,
  input  logic [1:0]        move,
  input  logic [NPC*CW-1:0] cand_x,
  input  logic [NPC*CW-1:0] cand_y,
  output logic              blocked,
  output logic [CELLS-1:0]  occ,
  output logic              row_full,
  output logic [SCW-1:0]    score
);

  logic  shift_fire;
  move_e move_q;

  assign move_q = move_e'(move);

  grid_store #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .NWR(NWR)) u_store (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
    .occ(occ), .row_full(row_full), .shift_fire(shift_fire)
  );

  grid_reader #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .NRD(NRD)) u_reader (
    .occ(occ), .rd_x(rd_x), .rd_y(rd_y), .rd_hit(rd_hit)
  );

  move_judge #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .NPC(NPC)) u_judge (
    .clk(clk), .rst_n(rst_n), .move(move_q),
    .cand_x(cand_x), .cand_y(cand_y), .occ(occ), .blocked(blocked)
  );

  row_score #(.SCW(SCW)) u_score (
    .clk(clk), .rst_n(rst_n), .bump(shift_fire), .score(score)
  );

endmodule

// File: tb/playfield_grid_bench.sv
module playfield_grid_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  wr_en = '0;
  logic [8:0]  wr_x = '0, wr_y = '0, rd_x = '0, rd_y = '0;
  logic [8:0]  cand_x = '0, cand_y = '0;
  logic [1:0]  move = 2'b00;
  logic [2:0]  rd_hit;
  logic        blocked, row_full;
  logic [34:0] occ;
  logic [7:0]  score;

  int checks = 0;
  int errors = 0;

  bit mg [7][5];
  int msc = 0;

  typedef struct {
    logic [34:0] occ;
    logic [7:0]  sc;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  playfield_grid u_playfield_grid (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
    .rd_x(rd_x), .rd_y(rd_y), .rd_hit(rd_hit),
    .move(move), .cand_x(cand_x), .cand_y(cand_y), .blocked(blocked),
    .occ(occ), .row_full(row_full), .score(score)
  );

  function automatic logic [34:0] model_vec();
    logic [34:0] v = '0;
    for (int r = 0; r < 7; r++)
      for (int k = 0; k < 5; k++)
        v[r*5 + k] = mg[r][k];
    return v;
  endfunction

  function automatic bit model_cell(int x, int y);
    if (x > 4 || y > 6) return 1'b0;
    return mg[y][x];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare registered results one edge after each driven step.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(occ == e.occ, {e.tag, " occ"}, 64'(occ), 64'(e.occ));
      chk(score == e.sc, {e.tag, " score"}, 64'(score), 64'(e.sc));
    end
  end

  // Driver: apply one cycle of stimulus and push the predicted state.
  task automatic step(input bit tk, input logic [2:0] en,
                      input int x0, input int y0, input int x1, input int y1,
                      input int x2, input int y2, input string tag);
    int xs[3];
    int ys[3];
    bit full;
    exp_t e;
    xs = '{x0, x1, x2};
    ys = '{y0, y1, y2};
    @(negedge clk);
    tick  = tk;
    wr_en = en;
    wr_x  = {3'(x2), 3'(x1), 3'(x0)};
    wr_y  = {3'(y2), 3'(y1), 3'(y0)};
    full = 1'b1;
    for (int k = 0; k < 5; k++) full &= mg[0][k];
    if (tk && full) begin
      for (int r = 0; r < 6; r++)
        for (int k = 0; k < 5; k++) mg[r][k] = mg[r+1][k];
      for (int k = 0; k < 5; k++) mg[6][k] = 1'b0;
      msc = (msc + 1) % 256;
    end
    for (int p = 0; p < 3; p++)
      if (en[p] && xs[p] < 5 && ys[p] < 7) mg[ys[p]][xs[p]] = 1'b1;
    e.occ = model_vec();
    e.sc  = 8'(msc);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    tick  = 1'b0;
    wr_en = '0;
  endtask

  task automatic probe(input int x0, input int y0, input int x1, input int y1,
                       input int x2, input int y2, input string tag);
    logic [2:0] exp;
    @(negedge clk);
    rd_x = {3'(x2), 3'(x1), 3'(x0)};
    rd_y = {3'(y2), 3'(y1), 3'(y0)};
    exp  = {model_cell(x2, y2), model_cell(x1, y1), model_cell(x0, y0)};
    #1;
    chk(rd_hit == exp, tag, 64'(rd_hit), 64'(exp));
  endtask

  task automatic judge(input logic [1:0] mv, input int x0, input int y0, input int x1,
                       input int y1, input int x2, input int y2, input string tag);
    int xs[3];
    int ys[3];
    bit bnd = 1'b0;
    bit hit = 1'b0;
    bit exp;
    xs = '{x0, x1, x2};
    ys = '{y0, y1, y2};
    for (int p = 0; p < 3; p++) begin
      if (mv == 2'b01 && xs[p] == 7) bnd = 1'b1;
      if (mv == 2'b10 && xs[p] == 5) bnd = 1'b1;
      if (mv == 2'b11 && ys[p] == 7) bnd = 1'b1;
      if (model_cell(xs[p], ys[p])) hit = 1'b1;
    end
    exp = (mv != 2'b00) && (bnd || hit);
    @(negedge clk);
    move   = mv;
    cand_x = {3'(x2), 3'(x1), 3'(x0)};
    cand_y = {3'(y2), 3'(y1), 3'(y0)};
    #1;
    chk(blocked == exp, tag, 64'(blocked), 64'(exp));
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #9;
    @(negedge clk);
    chk(occ == '0, "R1 reset occ", 64'(occ), 64'd0);
    chk(score == '0, "R1 reset score", 64'(score), 64'd0);
    rst_n = 1'b1;

    step(1'b0, 3'b111, 0, 0, 4, 6, 2, 3, "R3 three writes");
    step(1'b0, 3'b001, 5, 1, 0, 0, 0, 0, "R3 off-board write ignored");
    probe(0, 0, 4, 6, 2, 3, "R2 set cells");
    probe(1, 0, 5, 0, 7, 7, "R2 empty and off-board");

    step(1'b1, 3'b111, 1, 0, 2, 0, 3, 0, "R6 tick without full row");
    @(negedge clk);
    chk(row_full == 1'b0, "R5 four of five", 64'(row_full), 64'd0);
    step(1'b0, 3'b001, 4, 0, 0, 0, 0, 0, "R3 complete bottom");
    @(negedge clk);
    chk(row_full == 1'b1, "R5 bottom full", 64'(row_full), 64'd1);
    step(1'b0, 3'b000, 0, 0, 0, 0, 0, 0, "R6 no tick no shift");

    judge(2'b01, 7, 2, 0, 2, 1, 2, "R9 left edge");
    judge(2'b01, 1, 2, 2, 2, 3, 2, "R10 left free");
    judge(2'b11, 1, 7, 1, 5, 1, 4, "R9 down edge");
    judge(2'b10, 5, 1, 4, 1, 3, 1, "R9 right edge");
    judge(2'b10, 7, 1, 1, 1, 1, 2, "R10 off-board skip");
    judge(2'b11, 2, 2, 2, 3, 1, 1, "R10 occupied");
    judge(2'b00, 2, 3, 0, 0, 7, 7, "R10 no move");

    step(1'b1, 3'b001, 0, 6, 0, 0, 0, 0, "R8 shift then write");
    step(1'b0, 3'b000, 0, 0, 0, 0, 0, 0, "R7 score hold");
    probe(2, 2, 4, 5, 0, 6, "R6 rows moved down");

    step(1'b0, 3'b111, 0, 0, 1, 0, 2, 0, "R3 refill");
    step(1'b0, 3'b011, 3, 0, 4, 0, 0, 0, "R3 refill");
    step(1'b1, 3'b111, 0, 0, 1, 0, 2, 0, "R8 writes into new bottom");
    for (int i = 0; i < 254; i++) begin
      step(1'b0, 3'b011, 3, 0, 4, 0, 0, 0, "R3 loop fill");
      step(1'b1, 3'b111, 0, 0, 1, 0, 2, 0, "R7 loop clear");
    end
    @(negedge clk);
    chk(score == 8'd0, "R7 wrap", 64'(score), 64'd0);

    step(1'b0, 3'b001, 3, 3, 0, 0, 0, 0, "R4 cells persist");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(occ == '0, "R1 async clear occ", 64'(occ), 64'd0);
    chk(score == '0, "R1 async clear score", 64'(score), 64'd0);
    for (int r = 0; r < 7; r++)
      for (int k = 0; k < 5; k++) mg[r][k] = 1'b0;
    msc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule